// File: doc/BRIEF.md
# Counter Ownership Reservation Bitmap

This block is a per-core ownership register for performance-monitoring resources. Software agents use it to claim a hardware counter or an event-select register before they program it, and to give the claim back afterwards. It keeps two separate bitmaps. One covers the counter registers and one covers the event-select registers. Bit n of a map is set while resource n is owned.

A request names a register address, the map it belongs to and an operation. The block turns the address into a bit index. It does this by subtracting a base address, and the base depends on which of three counter families is configured. A reserve is an atomic test-and-set: it succeeds only when the bit was free. A release clears the bit. A query reports whether the bit is free, and it can address the bit either by register address or by raw index. Any index above 66 is rejected with an error, and a rejected request changes no state. The block accepts one request per cycle. The registered response appears on the following cycle.

Top module: `ctr_claim_map`

## Requirements
- R1: The counter map (`req_map`=0) and the event-select map (`req_map`=1) are independent. An operation on one map never changes the bits of the other.
- R2: For operations 0, 1 and 2, the bit index is `req_addr` minus a base chosen by `cfg_family` and `req_map`. The (counter, event-select) bases are: family 0 = (0x00C1, 0x0186), family 1 = (0x0300, 0x03A0), family 2 = (0x0400, 0x0500).
- R3: A request raises `rsp_err`=1 with `rsp_ok`=0 and leaves both maps unchanged when any of these holds: the index exceeds 66; the address is below the base; or `cfg_family`=3 with an operation other than 3.
- R4: Reserve (`req_op`=1) on a free bit sets that bit and returns `rsp_ok`=1. On an owned bit it returns `rsp_ok`=0 and leaves the map unchanged.
- R5: Release (`req_op`=2) clears the addressed bit whether or not it was set, and returns `rsp_ok`=1.
- R6: Query by address (`req_op`=0) returns `rsp_ok`=1 exactly when the addressed bit is free, and changes no state.
- R7: Query by raw index (`req_op`=3) uses `req_addr` itself as the index, independent of `cfg_family`. It follows the same free test and the same limit of 66.
- R8: After reset, every bit of both maps is free.
- R9: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. While `rsp_valid` is low, `rsp_ok` and `rsp_err` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_family | input | 2 | Counter family that selects the base addresses (0..2; 3 is invalid) |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 0 query by address, 1 reserve, 2 release, 3 query by raw index |
| req_map | input | 1 | 0 counter map, 1 event-select map |
| req_addr | input | ADDR_W | Register address, or the raw bit index for operation 3 |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ok | output | 1 | Free, reserve granted, or release done |
| rsp_err | output | 1 | Request rejected: index out of range or family invalid |

## Verification
Directed sequences exercise the three outcomes of a reserve on a single bit: granted on a free bit, refused on an owned bit, and granted again after a release. Running the same sequence on the other map shows that the two maps do not interact. Boundary addresses check the limits of the index range: index 66 is accepted, index 67 is rejected, and an address one below the base is rejected. Each family is used in turn, which separates a correct choice of base from a wrong one. Random mixes of all operations, families and addresses, including invalid ones, are compared against a reference bitmap. This exposes a rejected request that leaks a state change, and a query that alters state.

// File: rtl/ctr_claim_map.sv
module ctr_claim_map #(
  parameter int ADDR_W = 16,
  parameter int MAX_IDX = 66,
  parameter logic [15:0] F0_CNT_BASE = 16'h00C1,
  parameter logic [15:0] F0_SEL_BASE = 16'h0186,
  parameter logic [15:0] F1_CNT_BASE = 16'h0300,
  parameter logic [15:0] F1_SEL_BASE = 16'h03A0,
  parameter logic [15:0] F2_CNT_BASE = 16'h0400,
  parameter logic [15:0] F2_SEL_BASE = 16'h0500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_family,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_map,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic              rsp_err
);
  localparam int NBITS = MAX_IDX + 1;
  localparam int IDX_W = $clog2(NBITS);
  localparam logic [1:0] OP_QRY = 2'd0, OP_RES = 2'd1, OP_REL = 2'd2, OP_RAW = 2'd3;

  logic [NBITS-1:0] cnt_map, sel_map;
  logic [ADDR_W-1:0] base, diff, idx_full;
  logic fam_bad, below, err;
  logic [IDX_W-1:0] idx;
  logic cur_bit;

  always_comb begin
    fam_bad = 1'b0;
    case (cfg_family)
      2'd0: base = ADDR_W'(req_map ? F0_SEL_BASE : F0_CNT_BASE);
      2'd1: base = ADDR_W'(req_map ? F1_SEL_BASE : F1_CNT_BASE);
      2'd2: base = ADDR_W'(req_map ? F2_SEL_BASE : F2_CNT_BASE);
      default: begin base = '0; fam_bad = 1'b1; end
    endcase
  end

  assign diff     = req_addr - base;
  assign below    = req_addr < base;
  assign idx_full = (req_op == OP_RAW) ? req_addr : diff;
  assign err      = ((req_op != OP_RAW) && (fam_bad || below)) || (idx_full > ADDR_W'(MAX_IDX));
  assign idx      = idx_full[IDX_W-1:0];
  assign cur_bit  = err ? 1'b0 : (req_map ? sel_map[idx] : cnt_map[idx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_map   <= '0;
      sel_map   <= '0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ok    <= 1'b0;
      rsp_err   <= 1'b0;
      if (req_valid) begin
        if (err) begin
          rsp_err <= 1'b1;
        end else begin
          case (req_op)
            OP_RES: begin
              rsp_ok <= !cur_bit;
              if (req_map) sel_map[idx] <= 1'b1;
              else         cnt_map[idx] <= 1'b1;
            end
            OP_REL: begin
              rsp_ok <= 1'b1;
              if (req_map) sel_map[idx] <= 1'b0;
              else         cnt_map[idx] <= 1'b0;
            end
            default: rsp_ok <= !cur_bit;
          endcase
        end
      end
    end
  end
endmodule

module ctr_claim_map_chk #(parameter int NBITS = 67) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       req_op,
  input logic             req_map,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             rsp_err,
  input logic [NBITS-1:0] cnt_map,
  input logic [NBITS-1:0] sel_map
);
  assert_rsp_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_no_rsp_without_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_ok && !rsp_err));
  assert_err_excludes_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !rsp_ok);
  assert_err_keeps_maps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> ($stable(cnt_map) && $stable(sel_map)));
  assert_query_keeps_maps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_op == 2'd0 || req_op == 2'd3)) |=> ($stable(cnt_map) && $stable(sel_map)));
  assert_maps_independent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_map) |=> $stable(sel_map));
  assert_refused_reserve_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(req_op) == 2'd1 && !rsp_ok) |-> ($stable(cnt_map) && $stable(sel_map)));
endmodule

bind ctr_claim_map ctr_claim_map_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_map(req_map),
  .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_err(rsp_err),
  .cnt_map(cnt_map), .sel_map(sel_map));

// File: tb/ctr_claim_map_bench.sv
module ctr_claim_map_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic [1:0] cfg_family = 0;
  logic req_valid = 0;
  logic [1:0] req_op = 0;
  logic req_map = 0;
  logic [AW-1:0] req_addr = 0;
  logic rsp_valid, rsp_ok, rsp_err;

  int checks = 0, fails = 0;
  logic ref_map [2][67];

  always #(CLK_PERIOD/2) clk = ~clk;

  ctr_claim_map u_ctr_claim_map (.*);

  function automatic logic [15:0] base_of(input logic [1:0] f, input logic m);
    case (f)
      2'd0: return m ? 16'h0186 : 16'h00C1;
      2'd1: return m ? 16'h03A0 : 16'h0300;
      default: return m ? 16'h0500 : 16'h0400;
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic op(input string req, input logic [1:0] f, input logic [1:0] o,
                    input logic m, input logic [AW-1:0] a);
    logic e, ok;
    int ix;
    e = 0; ok = 0; ix = 0;
    if (o == 2'd3) begin
      ix = int'(a); e = (a > 66);
    end else if (f == 2'd3 || a < base_of(f, m)) e = 1;
    else begin
      ix = int'(a - base_of(f, m)); e = (ix > 66);
    end
    if (!e) begin
      case (o)
        2'd1: begin ok = !ref_map[m][ix]; ref_map[m][ix] = 1; end
        2'd2: begin ok = 1; ref_map[m][ix] = 0; end
        default: ok = !ref_map[m][ix];
      endcase
    end
    cfg_family = f; req_op = o; req_map = m; req_addr = a; req_valid = 1;
    @(posedge clk); #1;
    req_valid = 0;
    check({req, " valid"}, rsp_valid, 1'b1);
    check({req, " ok"}, rsp_ok, ok);
    check({req, " err"}, rsp_err, e);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int m = 0; m < 2; m++) for (int i = 0; i < 67; i++) ref_map[m][i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R9 idle valid", rsp_valid, 1'b0);
    // R8: all free after reset, both maps, edges of range
    op("R8", 2'd0, 2'd3, 0, 16'd0);
    op("R8", 2'd0, 2'd3, 1, 16'd66);
    op("R8", 2'd1, 2'd0, 0, 16'h0300 + 16'd33);
    // R4: reserve free, then refused
    op("R4", 2'd0, 2'd1, 0, 16'h00C1 + 16'd5);
    op("R4", 2'd0, 2'd1, 0, 16'h00C1 + 16'd5);
    // R1: other map same index still free
    op("R1", 2'd0, 2'd0, 1, 16'h0186 + 16'd5);
    op("R1", 2'd0, 2'd1, 1, 16'h0186 + 16'd5);
    // R2: same bit via other family base / raw index
    op("R2", 2'd1, 2'd0, 0, 16'h0300 + 16'd5);
    op("R2", 2'd2, 2'd1, 0, 16'h0400 + 16'd5);
    op("R7", 2'd3, 2'd3, 0, 16'd5);
    // R5: release then reserve again, release of free bit
    op("R5", 2'd0, 2'd2, 0, 16'h00C1 + 16'd5);
    op("R5", 2'd0, 2'd2, 0, 16'h00C1 + 16'd6);
    op("R5", 2'd0, 2'd1, 0, 16'h00C1 + 16'd5);
    // R3: boundaries
    op("R3", 2'd2, 2'd1, 1, 16'h0500 + 16'd66);
    op("R3", 2'd2, 2'd1, 1, 16'h0500 + 16'd67);
    op("R3", 2'd2, 2'd1, 1, 16'h0500 - 16'd1);
    op("R3", 2'd3, 2'd1, 0, 16'h00C1);
    op("R7", 2'd0, 2'd3, 0, 16'd67);
    // R6: query leaves map intact
    op("R6", 2'd0, 2'd0, 1, 16'h0186 + 16'd66);
    op("R6", 2'd0, 2'd1, 1, 16'h0186 + 16'd66);
    // random mix
    void'($urandom(32'd1234));
    for (int n = 0; n < 1500; n++) begin
      logic [1:0] f, o;
      logic m;
      logic [AW-1:0] a;
      f = 2'($urandom_range(0, 3));
      o = 2'($urandom_range(0, 3));
      m = 1'($urandom_range(0, 1));
      if (o == 2'd3) a = AW'($urandom_range(0, 70));
      else if (f == 2'd3) a = AW'($urandom_range(0, 16'h0600));
      else a = base_of(f, m) + AW'($urandom_range(0, 72)) - AW'($urandom_range(0, 2));
      op("R4/R5/R6 random", f, o, m, a);
      if ($urandom_range(0, 3) == 0) begin
        @(posedge clk); #1;
        check("R9 gap", rsp_valid | rsp_ok | rsp_err, 1'b0);
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule